// File: doc/BRIEF.md
# Indexed Banked Monitor Register File

This block is the register file of a hardware-monitor device, reached through two port locations. The first location holds a 7-bit index. The second location reads or writes the register that the index selects. Behind the port sits a 128-location main space. A few indices in that space are read-only, some make the index advance after each data access, and indices 0x60 to 0x7F fold onto 0x20 to 0x3F. A bank-select register can overlay the temperature window, indices 0x50 to 0x56, with a small private array for each alternate bank.

Sensor readings come in on plain input ports. They are captured into the value registers at reset, and the temperature words for the alternate banks are captured in the same way. Setting the top bit of the configuration register reloads every default and keeps only the configured bus address. A vendor-identification location returns either byte of a 16-bit parameter, chosen by a flag in the bank-select register.

Top module: `hwmon_regfile`

## Requirements
- R1: Writing the index location keeps only bits 6:0 of the written byte. A read of the index location returns the index with bit 7 at 0.
- R2: While bank 0 is active, any data-location read or write at index 0x41, 0x43, 0x45, 0x56 or 0x60..0x7E advances the index by one on the same clock edge. At any other index, or while any other bank is active, the index stays put.
- R3: A data access at an index in 0x60..0x7F reaches the same storage as the index with bit 6 cleared (index AND 0x3F).
- R4: Data writes to indices 0x20..0x2A, 0x41, 0x42, 0x4F, 0x58 and 0x60..0x6A leave the register unchanged.
- R5: Bits 2:0 of register 0x4E hold the active bank number in binary. With bank n in 1..NUM_BANKS and an index in 0x50..0x56, the access goes to bank n's 7-byte array at offset index-0x50. With a bank above NUM_BANKS, such a read returns 0xFF and such a write does nothing. Bank 0 always uses the main space.
- R6: In every alternate bank, offsets 0 and 1 (indices 0x50, 0x51) are read-only. After reset they hold the high and low byte of that bank's temperature input. Offsets 3 and 5 reset to 0x4B and 0x50, and the other offsets reset to 0x00.
- R7: A data read of index 0x4F returns VENDOR_ID[15:8] when bit 7 of register 0x4E is 1, and VENDOR_ID[7:0] when it is 0.
- R8: A data write to index 0x40 with bit 7 set reloads all register and bank defaults and recaptures the sensor inputs. Register 0x48 keeps its value, and the index is unchanged.
- R9: After reset the index is 0x00 and rdata is 0x00. Main registers read 0x40=0x08, 0x46=0x40, 0x47=0x50, 0x48=ADDR_DEFAULT, 0x49=0x02, 0x4B=0x44, 0x4C=0x01, 0x4D=0x15, 0x4E=0x80, 0x57=0x80. Other writable locations read 0x00.
- R10: rdata is registered. It changes only on the clock edge after a read strobe and holds at all other times. A cycle with both strobes set is a write only, and rdata holds.
- R11: After reset, index 0x20+k (k < SENSE_N) reads byte k of sens_in, bits 8k+7 down to 8k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_sel | input | 1 | 0 selects the index location, 1 selects the data location |
| rd_stb | input | 1 | Single-cycle read strobe |
| wr_stb | input | 1 | Single-cycle write strobe |
| wdata | input | 8 | Write data |
| sens_in | input | SENSE_N*8 | Sensor readings captured into 0x20 upward at reset |
| bank_temp | input | NUM_BANKS*16 | Temperature word per alternate bank, bank 1 in the low 16 bits |
| rdata | output | 8 | Registered read data |

## Verification
The bench builds the block with two alternate banks, eleven sensor bytes, a vendor word of 0xC3A5 whose two bytes differ, and bus-address default 0x2D. Because there are two banks, the bench can show that the arrays are isolated from each other. Because the select field is three bits wide, banks 3 to 7 can be selected and exercised as unmapped. The distinct vendor bytes and the distinct sensor values let each check tell apart the byte select, the alias fold and the read-only paths.

// File: rtl/hwm_pkg.sv
package hwm_pkg;
  localparam int IDX_W = 7;
  localparam int BYTE_W = 8;
  localparam int WIN_SLOTS = 8;
  localparam logic [6:0] IX_CONFIG  = 7'h40;
  localparam logic [6:0] IX_BUSADDR = 7'h48;
  localparam logic [6:0] IX_BANKSEL = 7'h4E;
  localparam logic [6:0] IX_VENDOR  = 7'h4F;
  localparam logic [6:0] IX_WIN_LO  = 7'h50;
  localparam logic [6:0] IX_WIN_HI  = 7'h56;

  function automatic logic is_readonly(input logic [6:0] ix);
    return (ix >= 7'h20 && ix <= 7'h2A) || (ix >= 7'h60 && ix <= 7'h6A) ||
           ix == 7'h41 || ix == 7'h42 || ix == 7'h4F || ix == 7'h58;
  endfunction

  function automatic logic is_autoinc(input logic [6:0] ix);
    return ix == 7'h41 || ix == 7'h43 || ix == 7'h45 || ix == 7'h56 ||
           (ix >= 7'h60 && ix <= 7'h7E);
  endfunction

  function automatic logic in_window(input logic [6:0] ix);
    return ix >= IX_WIN_LO && ix <= IX_WIN_HI;
  endfunction

  // upper alias quarter folds onto 0x20..0x3F
  function automatic logic [6:0] phys_of(input logic [6:0] ix);
    return (ix[6:5] == 2'b11) ? {2'b01, ix[4:0]} : ix;
  endfunction

  function automatic logic [7:0] main_default(input logic [6:0] ix);
    case (ix)
      7'h40: return 8'h08;
      7'h46: return 8'h40;
      7'h47: return 8'h50;
      7'h49: return 8'h02;
      7'h4B: return 8'h44;
      7'h4C: return 8'h01;
      7'h4D: return 8'h15;
      7'h4E: return 8'h80;
      7'h57: return 8'h80;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] bank_default(input logic [2:0] off);
    case (off)
      3'd3: return 8'h4B;
      3'd5: return 8'h50;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/hwm_index_reg.sv
module hwm_index_reg
  import hwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [IDX_W-1:0] load_val,
  input  logic             advance,
  output logic [IDX_W-1:0] idx
);
  always_ff @(posedge clk) begin
    if (rst)          idx <= '0;
    else if (load)    idx <= load_val;
    else if (advance) idx <= idx + 1'b1;
  end
endmodule

// File: rtl/hwm_main_space.sv
module hwm_main_space
  import hwm_pkg::*;
#(
  parameter int         SENSE_N      = 11,
  parameter logic [6:0] ADDR_DEFAULT = 7'h2D
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               soft_rst,
  input  logic [SENSE_N*8-1:0] sens_in,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_addr,
  input  logic [BYTE_W-1:0]  wr_data,
  input  logic [IDX_W-1:0]   rd_addr,
  output logic [BYTE_W-1:0]  rd_data,
  output logic [2:0]         bank_sel,
  output logic               vendor_hi
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int VALUE_BASE = 32;

  logic [BYTE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      for (int a = 0; a < DEPTH; a++) mem[a] <= main_default(7'(a));
      for (int s = 0; s < SENSE_N; s++) mem[VALUE_BASE + s] <= sens_in[s*8 +: 8];
      mem[IX_BUSADDR] <= rst ? {1'b0, ADDR_DEFAULT} : mem[IX_BUSADDR];
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign rd_data   = mem[rd_addr];
  assign bank_sel  = mem[IX_BANKSEL][2:0];
  assign vendor_hi = mem[IX_BANKSEL][7];
endmodule

// File: rtl/hwm_alt_bank.sv
module hwm_alt_bank
  import hwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [15:0]       temp_in,
  input  logic              wr_en,
  input  logic [2:0]        wr_off,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [2:0]        rd_off,
  output logic [BYTE_W-1:0] rd_data
);
  logic [BYTE_W-1:0] arr [WIN_SLOTS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int o = 0; o < WIN_SLOTS; o++) arr[o] <= bank_default(3'(o));
      arr[0] <= temp_in[15:8];
      arr[1] <= temp_in[7:0];
    end else if (wr_en && wr_off >= 3'd2) begin
      arr[wr_off] <= wr_data;
    end
  end

  assign rd_data = arr[rd_off];
endmodule

// File: rtl/hwmon_regfile.sv
module hwmon_regfile
  import hwm_pkg::*;
#(
  parameter int          NUM_BANKS    = 2,
  parameter int          SENSE_N      = 11,
  parameter logic [15:0] VENDOR_ID    = 16'h1234,
  parameter logic [6:0]  ADDR_DEFAULT = 7'h2D
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   port_sel,
  input  logic                   rd_stb,
  input  logic                   wr_stb,
  input  logic [7:0]             wdata,
  input  logic [SENSE_N*8-1:0]   sens_in,
  input  logic [NUM_BANKS*16-1:0] bank_temp,
  output logic [7:0]             rdata
);
  logic [IDX_W-1:0]  idx;
  logic [2:0]        bank;
  logic              vendor_hi;
  logic [BYTE_W-1:0] main_rd;
  logic [BYTE_W-1:0] bank_rd [NUM_BANKS];
  logic [BYTE_W-1:0] rd_val;

  logic idx_rd, idx_wr, data_rd, data_wr, bank_hit, soft_rst, main_wr, advance;
  logic [2:0] win_off;

  assign idx_wr   = wr_stb && !port_sel;
  assign idx_rd   = rd_stb && !wr_stb && !port_sel;
  assign data_wr  = wr_stb && port_sel;
  assign data_rd  = rd_stb && !wr_stb && port_sel;
  assign bank_hit = (bank != 3'd0) && in_window(idx);
  assign win_off  = 3'(idx - IX_WIN_LO);
  assign soft_rst = data_wr && !bank_hit && idx == IX_CONFIG && wdata[7];
  assign main_wr  = data_wr && !bank_hit && !is_readonly(idx) && !soft_rst;
  assign advance  = (data_rd || data_wr) && bank == 3'd0 && is_autoinc(idx);

  hwm_index_reg u_index (
    .clk(clk), .rst(rst), .load(idx_wr), .load_val(wdata[6:0]),
    .advance(advance), .idx(idx)
  );

  hwm_main_space #(.SENSE_N(SENSE_N), .ADDR_DEFAULT(ADDR_DEFAULT)) u_main (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .sens_in(sens_in),
    .wr_en(main_wr), .wr_addr(phys_of(idx)), .wr_data(wdata),
    .rd_addr(phys_of(idx)), .rd_data(main_rd),
    .bank_sel(bank), .vendor_hi(vendor_hi)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    hwm_alt_bank u_bank (
      .clk(clk), .rst(rst || soft_rst), .temp_in(bank_temp[b*16 +: 16]),
      .wr_en(data_wr && bank_hit && bank == 3'(b + 1)),
      .wr_off(win_off), .wr_data(wdata),
      .rd_off(win_off), .rd_data(bank_rd[b])
    );
  end

  always_comb begin
    rd_val = 8'hFF;
    if (bank_hit) begin
      for (int b = 0; b < NUM_BANKS; b++)
        if (bank == 3'(b + 1)) rd_val = bank_rd[b];
    end else if (idx == IX_VENDOR) begin
      rd_val = vendor_hi ? VENDOR_ID[15:8] : VENDOR_ID[7:0];
    end else begin
      rd_val = main_rd;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata <= 8'h00;
    else if (idx_rd)  rdata <= {1'b0, idx};
    else if (data_rd) rdata <= rd_val;
  end
endmodule

// File: rtl/hwmon_regfile_chk.sv
module hwmon_regfile_chk
  import hwm_pkg::*;
#(
  parameter int NUM_BANKS = 2
) (
  input logic       clk,
  input logic       rst,
  input logic       port_sel,
  input logic       rd_stb,
  input logic       wr_stb,
  input logic       wdata_msb,
  input logic [7:0] rdata,
  input logic [6:0] idx,
  input logic [2:0] bank
);
  a_r1_index_read_7bit: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !wr_stb && !port_sel) |=> (rdata[7] == 1'b0));

  a_r2_autoinc_step: assert property (@(posedge clk) disable iff (rst)
    ((rd_stb || wr_stb) && port_sel && bank == 3'd0 && is_autoinc(idx))
      |=> (idx == $past(idx) + 7'd1));

  a_r5_unmapped_bank_ff: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !wr_stb && port_sel && int'(bank) > NUM_BANKS && in_window(idx))
      |=> (rdata == 8'hFF));

  a_r8_softreset_bank0: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && port_sel && idx == 7'h40 && wdata_msb) |=> (bank == 3'd0));

  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    (!rd_stb || wr_stb) |=> $stable(rdata));
endmodule

bind hwmon_regfile hwmon_regfile_chk #(.NUM_BANKS(NUM_BANKS)) chk_i (
  .clk(clk), .rst(rst), .port_sel(port_sel), .rd_stb(rd_stb), .wr_stb(wr_stb),
  .wdata_msb(wdata[7]), .rdata(rdata), .idx(idx), .bank(bank)
);

// File: tb/hwmon_regfile_tb_top.sv
module hwmon_regfile_tb_top;
  localparam int          NB   = 2;
  localparam int          SN   = 11;
  localparam logic [15:0] VID  = 16'hC3A5;
  localparam logic [6:0]  ADEF = 7'h2D;

  logic clk = 1'b0, rst = 1'b1, port_sel = 1'b0, rd_stb = 1'b0, wr_stb = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [SN*8-1:0] sens_in;
  logic [NB*16-1:0] bank_temp;
  logic [7:0] rdata;

  always #4 clk = ~clk;

  hwmon_regfile #(.NUM_BANKS(NB), .SENSE_N(SN), .VENDOR_ID(VID), .ADDR_DEFAULT(ADEF)) dut_i (
    .clk(clk), .rst(rst), .port_sel(port_sel), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .wdata(wdata), .sens_in(sens_in), .bank_temp(bank_temp), .rdata(rdata)
  );

  int checks = 0, fails = 0;
  bit live = 0, done = 0;
  int m_main[128];
  int m_bank[8][8];
  int m_idx, m_rdata;

  function automatic int sens_byte(int k); return 'h10 + k * 7; endfunction
  function automatic int temp_hi(int b); return 'h31 + b; endfunction

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%02h expected=%02h", req, got, exp);
    end
  endtask

  function automatic bit m_ro(int i);
    return (i >= 'h20 && i <= 'h2a) || (i >= 'h60 && i <= 'h6a) ||
           i == 'h41 || i == 'h42 || i == 'h4f || i == 'h58;
  endfunction
  function automatic bit m_inc(int i);
    return i == 'h41 || i == 'h43 || i == 'h45 || i == 'h56 || (i >= 'h60 && i <= 'h7e);
  endfunction

  task automatic model_reset(bit keep_addr);
    int saved = m_main['h48];
    int dv[int] = '{'h40:'h08, 'h46:'h40, 'h47:'h50, 'h49:'h02, 'h4b:'h44,
                    'h4c:'h01, 'h4d:'h15, 'h4e:'h80, 'h57:'h80};
    for (int i = 0; i < 128; i++) m_main[i] = dv.exists(i) ? dv[i] : 0;
    for (int k = 0; k < SN; k++) m_main['h20 + k] = sens_byte(k);
    m_main['h48] = keep_addr ? saved : int'(ADEF);
    for (int b = 1; b <= NB; b++) begin
      for (int o = 0; o < 8; o++) m_bank[b][o] = 0;
      m_bank[b][0] = temp_hi(b - 1); m_bank[b][1] = 'h80;
      m_bank[b][3] = 'h4b; m_bank[b][5] = 'h50;
    end
  endtask

  task automatic model_step(bit ps, bit rd, bit wr, int d);
    int bank = m_main['h4e] & 7;
    int i = m_idx;
    bit win = (i >= 'h50 && i <= 'h56);
    int loc = (i >= 'h60) ? i - 'h40 : i;
    if (wr && !ps) m_idx = d & 'h7f;
    else if (rd && !ps) m_rdata = m_idx;
    else if (ps && (rd || wr)) begin
      if (wr) begin
        if (bank != 0 && win) begin
          if (bank <= NB && i - 'h50 >= 2) m_bank[bank][i - 'h50] = d;
        end else if (i == 'h40 && (d & 'h80) != 0) model_reset(1);
        else if (!m_ro(i)) m_main[loc] = d;
      end else begin
        if (bank != 0 && win) m_rdata = (bank <= NB) ? m_bank[bank][i - 'h50] : 'hff;
        else if (i == 'h4f) m_rdata = ((m_main['h4e] >> 7) & 1) ? int'(VID[15:8]) : int'(VID[7:0]);
        else m_rdata = m_main[loc];
      end
      if (bank == 0 && m_inc(i)) m_idx = (m_idx + 1) & 'h7f;
    end
  endtask

  // per-clock comparison against the reference model (R10)
  always @(negedge clk) if (live && !rst) check("R10 model", int'(rdata), m_rdata);

  task automatic op(bit ps, bit rd, bit wr, int d);
    @(negedge clk);
    port_sel = ps; rd_stb = rd; wr_stb = wr; wdata = d[7:0];
    @(posedge clk);
    model_step(ps, rd, wr, d);
    #1; rd_stb = 1'b0; wr_stb = 1'b0;
  endtask

  task automatic set_idx(int ix); op(0, 0, 1, ix); endtask
  task automatic wr_at(int ix, int d); set_idx(ix); op(1, 0, 1, d); endtask
  task automatic rd_at(int ix, int exp, string req);
    set_idx(ix); op(1, 1, 0, 0);
    @(negedge clk); check(req, int'(rdata), exp);
  endtask
  task automatic rd_idx(int exp, string req);
    op(0, 1, 0, 0);
    @(negedge clk); check(req, int'(rdata), exp);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog got=00 expected=01");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < SN; k++) sens_in[k*8 +: 8] = 8'(sens_byte(k));
    for (int b = 0; b < NB; b++) bank_temp[b*16 +: 16] = {8'(temp_hi(b)), 8'h80};
    model_reset(0);
    m_idx = 0; m_rdata = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0; live = 1;
    check("R9 rdata", int'(rdata), 0);
    rd_idx('h00, "R9 index");
    // R9 defaults
    rd_at('h40, 'h08, "R9 0x40"); rd_at('h46, 'h40, "R9 0x46");
    rd_at('h47, 'h50, "R9 0x47"); rd_at('h48, 'h2d, "R9 0x48");
    rd_at('h49, 'h02, "R9 0x49"); rd_at('h4b, 'h44, "R9 0x4B");
    rd_at('h4c, 'h01, "R9 0x4C"); rd_at('h4d, 'h15, "R9 0x4D");
    rd_at('h4e, 'h80, "R9 0x4E"); rd_at('h57, 'h80, "R9 0x57");
    rd_at('h3f, 'h00, "R9 other");
    // R11 sensor capture
    for (int k = 0; k < SN; k++) rd_at('h20 + k, sens_byte(k), "R11 sensor");
    // R1 index width
    set_idx('hc5); rd_idx('h45, "R1 index masked");
    // R2 auto advance
    rd_at('h41, 'h00, "R2 read 0x41"); rd_idx('h42, "R2 advance 0x41");
    rd_at('h42, 'h00, "R2 read 0x42"); rd_idx('h42, "R2 no advance 0x42");
    wr_at('h43, 'h11); rd_idx('h44, "R2 write advance 0x43");
    rd_at('h60, sens_byte(0), "R2 read 0x60"); rd_idx('h61, "R2 advance 0x60");
    rd_at('h7e, 'h00, "R2 read 0x7E"); rd_idx('h7f, "R2 advance 0x7E");
    rd_at('h7f, 'h00, "R2 read 0x7F"); rd_idx('h7f, "R2 no advance 0x7F");
    // R3 alias
    wr_at('h30, 'h5a); rd_at('h70, 'h5a, "R3 alias read");
    wr_at('h75, 'h77); rd_at('h35, 'h77, "R3 alias write");
    // R4 read-only
    wr_at('h25, 'hee); rd_at('h25, sens_byte(5), "R4 value reg");
    wr_at('h65, 'hee); rd_at('h25, sens_byte(5), "R4 alias ro");
    wr_at('h58, 'hee); rd_at('h58, 'h00, "R4 0x58");
    wr_at('h42, 'hee); rd_at('h42, 'h00, "R4 0x42");
    // R7 vendor byte
    rd_at('h4f, 'hc3, "R7 high byte");
    wr_at('h4e, 'h00); rd_at('h4f, 'ha5, "R7 low byte");
    // R5 / R6 banks
    wr_at('h4e, 'h01);
    rd_at('h53, 'h4b, "R6 bank1 0x53");
    wr_at('h53, 'h99); rd_at('h53, 'h99, "R5 bank1 write");
    rd_at('h55, 'h50, "R6 bank1 0x55");
    rd_at('h50, temp_hi(0), "R6 bank1 temp hi"); rd_at('h51, 'h80, "R6 bank1 temp lo");
    wr_at('h50, 'h00); rd_at('h50, temp_hi(0), "R6 temp read-only");
    rd_at('h56, 'h00, "R2 bank1 read 0x56"); rd_idx('h56, "R2 no advance bank1");
    wr_at('h4e, 'h02);
    rd_at('h53, 'h4b, "R5 bank2 isolated"); rd_at('h50, temp_hi(1), "R6 bank2 temp");
    wr_at('h4e, 'h05);
    rd_at('h52, 'hff, "R5 unmapped bank read");
    wr_at('h54, 'h12); rd_at('h54, 'hff, "R5 unmapped bank write");
    wr_at('h4e, 'h00);
    rd_at('h53, 'h00, "R5 bank0 main");
    // R10 both strobes
    rd_at('h46, 'h40, "R10 before");
    op(1, 1, 1, 'h3c);
    @(negedge clk); check("R10 hold on write", int'(rdata), 'h40);
    rd_at('h46, 'h3c, "R10 write applied");
    // R8 soft reset
    wr_at('h48, 'h1c); wr_at('h4e, 'h01); wr_at('h53, 'h66);
    set_idx('h40); op(1, 0, 1, 'h80);
    rd_idx('h40, "R8 index kept");
    rd_at('h48, 'h1c, "R8 address kept");
    rd_at('h30, 'h00, "R8 0x30 cleared");
    rd_at('h40, 'h08, "R8 0x40 default");
    rd_at('h4e, 'h80, "R8 bank select default");
    wr_at('h4e, 'h01); rd_at('h53, 'h4b, "R8 bank default");
    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule